// File: doc/BRIEF.md
# Per-Bank Load Summary Broadcaster

Each bank scheduler in a multi-bank memory controller keeps a running figure for every thread: the total processing time that thread currently has queued at that bank. This block holds those per-thread figures and, when asked, shares them with the other banks over a bounded number of synchronous rounds. Two ports keep the figures current. One adds a cost when a request is queued. The other removes a cost when a request is served.

A start pulse freezes a copy of all per-thread loads. The frozen loads are split into a long set and a short set. The long set holds the `T = NUM_THREADS / K` threads with the largest loads. The short set holds the rest. On each round tick the block emits at most one message. It first sends the long-set threads one at a time, each with its exact load. It then sends one message carrying the floor of the mean of the short-set loads. A done pulse marks the end of the exchange. With `K = 1` every thread is sent exactly and no averaged message exists.

The controller has four named states:
- `ST_IDLE` moves to `ST_LONG` on start.
- `ST_LONG` stays put on each tick until the T-th exact message has been sent. It then moves to `ST_AVG`, or to `ST_FIN` when the short set is empty.
- `ST_AVG` moves to `ST_FIN` on its tick.
- `ST_FIN` returns to `ST_IDLE` one cycle later and raises done.

Top module: `load_summary_bcast`

## Requirements
- R1: After reset all message outputs and `done` are 0 and every thread's load is 0. An exchange started straight after reset therefore sends thread IDs 0,1,...,T-1 with value 0, followed by an average of 0.
- R2: A pulse on `add_valid` adds `add_cost` to thread `add_tid`, saturating at all ones. A pulse on `ret_valid` subtracts `ret_cost` from thread `ret_tid`, clamping at 0.
- R3: `start` in `ST_IDLE` freezes the loads as they stood before that edge. Load updates made during the exchange do not change its messages, but they do appear in the next exchange.
- R4: A message is produced only in the cycle after a cycle in which `rnd_tick` was high, and at most one per tick. No message appears in any cycle that does not follow a tick.
- R5: The first T messages have `msg_is_avg` = 0. Each carries a long-set thread ID and its exact frozen load. They are sent in descending load order, and equal loads go out lower thread ID first.
- R6: When T < NUM_THREADS, message T+1 has `msg_is_avg` = 1 and `msg_tid` = 0. Its `msg_val` is the sum of the short-set loads divided by (NUM_THREADS - T), rounded down.
- R7: When T = NUM_THREADS (K = 1), exactly NUM_THREADS exact messages are sent and no averaged message is sent.
- R8: `done` is high for exactly one cycle, in the cycle after the cycle that carried the last message.
- R9: `start` is ignored while an exchange is in progress.
- R10: `rnd_tick` is ignored in `ST_IDLE`: no message appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| add_valid | input | 1 | Add a queued cost |
| add_tid | input | TID_W | Thread that receives the added cost |
| add_cost | input | VAL_W | Cost to add |
| ret_valid | input | 1 | Remove a served cost |
| ret_tid | input | TID_W | Thread whose cost is removed |
| ret_cost | input | VAL_W | Cost to remove |
| start | input | 1 | Begin an exchange (honoured only in `ST_IDLE`) |
| rnd_tick | input | 1 | Marks one broadcast round |
| msg_valid | output | 1 | A message is present this cycle |
| msg_is_avg | output | 1 | 1 = averaged short-set message, 0 = exact message |
| msg_tid | output | TID_W | Thread ID (0 for the averaged message) |
| msg_val | output | VAL_W | Exact load or short-set average |
| done | output | 1 | One-cycle pulse after the last message |

## Verification
Several properties are checked on every cycle:
- a message never appears without a preceding tick;
- exact messages never rise in value within an exchange;
- the averaged message is always the (T+1)-th and carries thread 0;
- no exchange emits more than its allotted message count;
- done is always a lone pulse right after a message.

Which threads are chosen, how ties are broken and what the arithmetic produces can only be shown by the bench's scenarios. The same holds for saturation and clamping, for freezing the loads, and for ignoring start and idle ticks. In those scenarios the expected values come from load patterns computed by hand.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LONG = 2'd1,
        ST_AVG  = 2'd2,
        ST_FIN  = 2'd3
    } lsb_state_t;

endpackage

// File: rtl/lsb_load_table.sv
module lsb_load_table #(
    parameter int N     = 8,
    parameter int VAL_W = 16,
    parameter int TID_W = 3,
    parameter int SUM_W = 19
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       add_valid,
    input  logic [TID_W-1:0]           add_tid,
    input  logic [VAL_W-1:0]           add_cost,
    input  logic                       ret_valid,
    input  logic [TID_W-1:0]           ret_tid,
    input  logic [VAL_W-1:0]           ret_cost,
    input  logic                       snap_en,
    output logic [N-1:0][VAL_W-1:0]    snap_vals,
    output logic [SUM_W-1:0]           snap_total
);

    logic [N-1:0][VAL_W-1:0] live_q;
    logic [N-1:0][VAL_W-1:0] live_d;
    logic [SUM_W-1:0]        live_sum;

    // One saturating add / clamping subtract per thread
    for (genvar g = 0; g < N; g++) begin : g_thread
        logic [VAL_W:0]   inc;
        logic [VAL_W-1:0] sat;
        logic             add_hit;
        logic             ret_hit;

        always_comb begin
            add_hit = add_valid && (add_tid == TID_W'(g));
            ret_hit = ret_valid && (ret_tid == TID_W'(g));
            inc     = {1'b0, live_q[g]} + (add_hit ? {1'b0, add_cost} : '0);
            sat     = inc[VAL_W] ? {VAL_W{1'b1}} : inc[VAL_W-1:0];
            if (ret_hit) begin
                live_d[g] = (sat < ret_cost) ? '0 : (sat - ret_cost);
            end else begin
                live_d[g] = sat;
            end
        end
    end

    always_comb begin
        live_sum = '0;
        for (int i = 0; i < N; i++) begin
            live_sum = live_sum + SUM_W'(live_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q     <= '0;
            snap_vals  <= '0;
            snap_total <= '0;
        end else begin
            live_q <= live_d;
            if (snap_en) begin
                snap_vals  <= live_q;
                snap_total <= live_sum;
            end
        end
    end

endmodule

// File: rtl/lsb_pick_max.sv
module lsb_pick_max #(
    parameter int N     = 8,
    parameter int VAL_W = 16,
    parameter int TID_W = 3
) (
    input  logic [N-1:0][VAL_W-1:0] vals,
    input  logic [N-1:0]            sent,
    output logic [TID_W-1:0]        best_tid,
    output logic [VAL_W-1:0]        best_val
);

    logic found;

    // Ascending scan with strict compare: on equal loads the lower ID stays
    always_comb begin
        best_tid = '0;
        best_val = '0;
        found    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!sent[i] && (!found || (vals[i] > best_val))) begin
                best_tid = TID_W'(i);
                best_val = vals[i];
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lsb_ctrl.sv
module lsb_ctrl
    import lsb_pkg::*;
#(
    parameter int N       = 8,
    parameter int T       = 4,
    parameter int VAL_W   = 16,
    parameter int TID_W   = 3,
    parameter int SUM_W   = 19,
    parameter int CNT_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               rnd_tick,
    input  logic [TID_W-1:0]   pick_tid,
    input  logic [VAL_W-1:0]   pick_val,
    input  logic [SUM_W-1:0]   snap_total,
    output logic               snap_en,
    output logic [N-1:0]       sent,
    output logic               msg_valid,
    output logic               msg_is_avg,
    output logic [TID_W-1:0]   msg_tid,
    output logic [VAL_W-1:0]   msg_val,
    output logic               done
);

    localparam int SHORT_N   = N - T;
    localparam int SHORT_DIV = (SHORT_N > 0) ? SHORT_N : 1;
    localparam bit HAS_AVG   = (SHORT_N > 0);

    lsb_state_t       state_q;
    lsb_state_t       state_d;
    logic [CNT_W-1:0] sent_cnt;
    logic [SUM_W-1:0] sent_sum;
    logic [SUM_W-1:0] short_sum;
    logic [SUM_W-1:0] avg_full;
    logic             last_long;

    assign snap_en   = start && (state_q == ST_IDLE);
    assign last_long = (sent_cnt == CNT_W'(T - 1));
    assign short_sum = snap_total - sent_sum;
    assign avg_full  = short_sum / SUM_W'(SHORT_DIV);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LONG;
            ST_LONG: begin
                if (rnd_tick && last_long) begin
                    state_d = HAS_AVG ? ST_AVG : ST_FIN;
                end
            end
            ST_AVG:  if (rnd_tick) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Round bookkeeping for the long set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent     <= '0;
            sent_cnt <= '0;
            sent_sum <= '0;
        end else if (snap_en) begin
            sent     <= '0;
            sent_cnt <= '0;
            sent_sum <= '0;
        end else if ((state_q == ST_LONG) && rnd_tick) begin
            sent[pick_tid] <= 1'b1;
            sent_cnt       <= sent_cnt + 1'b1;
            sent_sum       <= sent_sum + SUM_W'(pick_val);
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid  <= 1'b0;
            msg_is_avg <= 1'b0;
            msg_tid    <= '0;
            msg_val    <= '0;
            done       <= 1'b0;
        end else begin
            msg_valid <= 1'b0;
            done      <= (state_q == ST_FIN);
            unique case (state_q)
                ST_LONG: begin
                    if (rnd_tick) begin
                        msg_valid  <= 1'b1;
                        msg_is_avg <= 1'b0;
                        msg_tid    <= pick_tid;
                        msg_val    <= pick_val;
                    end
                end
                ST_AVG: begin
                    if (rnd_tick) begin
                        msg_valid  <= 1'b1;
                        msg_is_avg <= 1'b1;
                        msg_tid    <= '0;
                        msg_val    <= avg_full[VAL_W-1:0];
                    end
                end
                ST_IDLE, ST_FIN: ;
            endcase
        end
    end

endmodule

// File: rtl/load_summary_bcast.sv
module load_summary_bcast #(
    parameter int NUM_THREADS = 8,
    parameter int K           = 2,
    parameter int VAL_W       = 16,
    parameter int TID_W       = $clog2(NUM_THREADS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_valid,
    input  logic [TID_W-1:0]  add_tid,
    input  logic [VAL_W-1:0]  add_cost,
    input  logic              ret_valid,
    input  logic [TID_W-1:0]  ret_tid,
    input  logic [VAL_W-1:0]  ret_cost,
    input  logic              start,
    input  logic              rnd_tick,
    output logic              msg_valid,
    output logic              msg_is_avg,
    output logic [TID_W-1:0]  msg_tid,
    output logic [VAL_W-1:0]  msg_val,
    output logic              done
);

    localparam int T       = NUM_THREADS / K;
    localparam int SHORT_N = NUM_THREADS - T;
    localparam int SUM_W   = VAL_W + $clog2(NUM_THREADS + 1);
    localparam int CNT_W   = $clog2(T + 1);

    logic [NUM_THREADS-1:0][VAL_W-1:0] snap_vals;
    logic [SUM_W-1:0]                  snap_total;
    logic [NUM_THREADS-1:0]            sent;
    logic                              snap_en;
    logic [TID_W-1:0]                  pick_tid;
    logic [VAL_W-1:0]                  pick_val;

    lsb_load_table #(
        .N(NUM_THREADS), .VAL_W(VAL_W), .TID_W(TID_W), .SUM_W(SUM_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .add_valid(add_valid), .add_tid(add_tid), .add_cost(add_cost),
        .ret_valid(ret_valid), .ret_tid(ret_tid), .ret_cost(ret_cost),
        .snap_en(snap_en), .snap_vals(snap_vals), .snap_total(snap_total)
    );

    lsb_pick_max #(
        .N(NUM_THREADS), .VAL_W(VAL_W), .TID_W(TID_W)
    ) u_pick (
        .vals(snap_vals), .sent(sent),
        .best_tid(pick_tid), .best_val(pick_val)
    );

    lsb_ctrl #(
        .N(NUM_THREADS), .T(T), .VAL_W(VAL_W), .TID_W(TID_W),
        .SUM_W(SUM_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .rnd_tick(rnd_tick),
        .pick_tid(pick_tid), .pick_val(pick_val), .snap_total(snap_total),
        .snap_en(snap_en), .sent(sent),
        .msg_valid(msg_valid), .msg_is_avg(msg_is_avg),
        .msg_tid(msg_tid), .msg_val(msg_val), .done(done)
    );

endmodule

// File: rtl/lsb_checker.sv
module lsb_checker #(
    parameter int NUM_THREADS = 8,
    parameter int K           = 2,
    parameter int VAL_W       = 16,
    parameter int TID_W       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rnd_tick,
    input logic             msg_valid,
    input logic             msg_is_avg,
    input logic [TID_W-1:0] msg_tid,
    input logic [VAL_W-1:0] msg_val,
    input logic             done
);

    localparam int T       = NUM_THREADS / K;
    localparam bit HAS_AVG = (NUM_THREADS - T) > 0;
    localparam int MAX_MSG = T + (HAS_AVG ? 1 : 0);
    localparam int CW      = $clog2(MAX_MSG + 2);

    logic [CW-1:0]    msg_cnt;
    logic [VAL_W-1:0] last_val;
    logic             have_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_cnt   <= '0;
            last_val  <= '0;
            have_prev <= 1'b0;
        end else if (done) begin
            msg_cnt   <= '0;
            have_prev <= 1'b0;
        end else if (msg_valid) begin
            msg_cnt <= msg_cnt + 1'b1;
            if (!msg_is_avg) begin
                last_val  <= msg_val;
                have_prev <= 1'b1;
            end
        end
    end

    // R4
    msg_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $past(rnd_tick));

    // R4
    msg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_cnt < CW'(MAX_MSG)));

    // R5
    desc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_is_avg && have_prev) |-> (msg_val <= last_val));

    // R6
    avg_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_is_avg) |-> ((msg_cnt == CW'(T)) && (msg_tid == '0)));

    // R7
    no_avg_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !HAS_AVG) |-> !msg_is_avg);

    // R8
    done_after_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(msg_valid) && !msg_valid));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind load_summary_bcast lsb_checker #(
    .NUM_THREADS(NUM_THREADS), .K(K), .VAL_W(VAL_W), .TID_W(TID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rnd_tick(rnd_tick),
    .msg_valid(msg_valid), .msg_is_avg(msg_is_avg),
    .msg_tid(msg_tid), .msg_val(msg_val), .done(done)
);

// File: tb/load_summary_bcast_bench.sv
`timescale 1ns/1ps
module load_summary_bcast_bench;

    localparam int N  = 8;
    localparam int VW = 16;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          add_valid = 1'b0;
    logic [TW-1:0] add_tid = '0;
    logic [VW-1:0] add_cost = '0;
    logic          ret_valid = 1'b0;
    logic [TW-1:0] ret_tid = '0;
    logic [VW-1:0] ret_cost = '0;
    logic          start = 1'b0;
    logic          start_f = 1'b0;
    logic          rnd_tick = 1'b0;

    logic          msg_valid, msg_is_avg, done;
    logic [TW-1:0] msg_tid;
    logic [VW-1:0] msg_val;
    logic          f_valid, f_is_avg, f_done;
    logic [TW-1:0] f_tid;
    logic [VW-1:0] f_val;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    load_summary_bcast #(.NUM_THREADS(N), .K(2), .VAL_W(VW)) u_load_summary_bcast (
        .clk(clk), .rst_n(rst_n),
        .add_valid(add_valid), .add_tid(add_tid), .add_cost(add_cost),
        .ret_valid(ret_valid), .ret_tid(ret_tid), .ret_cost(ret_cost),
        .start(start), .rnd_tick(rnd_tick),
        .msg_valid(msg_valid), .msg_is_avg(msg_is_avg),
        .msg_tid(msg_tid), .msg_val(msg_val), .done(done)
    );

    load_summary_bcast #(.NUM_THREADS(N), .K(1), .VAL_W(VW)) u_full (
        .clk(clk), .rst_n(rst_n),
        .add_valid(add_valid), .add_tid(add_tid), .add_cost(add_cost),
        .ret_valid(ret_valid), .ret_tid(ret_tid), .ret_cost(ret_cost),
        .start(start_f), .rnd_tick(rnd_tick),
        .msg_valid(f_valid), .msg_is_avg(f_is_avg),
        .msg_tid(f_tid), .msg_val(f_val), .done(f_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic add(input int tid, input int cost);
        add_valid = 1'b1; add_tid = TW'(tid); add_cost = VW'(cost);
        @(negedge clk);
        add_valid = 1'b0;
    endtask

    task automatic retire(input int tid, input int cost);
        ret_valid = 1'b1; ret_tid = TW'(tid); ret_cost = VW'(cost);
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic pulse_start(input bit full);
        if (full) start_f = 1'b1; else start = 1'b1;
        @(negedge clk);
        start = 1'b0; start_f = 1'b0;
    endtask

    // Tick for one cycle; on return the registered message is visible
    task automatic tick();
        rnd_tick = 1'b1;
        @(negedge clk);
        rnd_tick = 1'b0;
    endtask

    task automatic expect_msg(input string req, input bit is_avg, input int tid, input int val);
        chk(msg_valid == 1'b1, req, msg_valid, 1);
        chk(msg_is_avg == is_avg, req, msg_is_avg, is_avg);
        chk(msg_tid == TW'(tid), req, msg_tid, tid);
        chk(msg_val == VW'(val), req, msg_val, val);
    endtask

    task automatic expect_full(input string req, input int tid, input int val);
        chk(f_valid == 1'b1, req, f_valid, 1);
        chk(f_is_avg == 1'b0, req, f_is_avg, 0);
        chk(f_tid == TW'(tid), req, f_tid, tid);
        chk(f_val == VW'(val), req, f_val, val);
    endtask

    // Sampled at the negedge carrying the last message
    task automatic expect_done_after(input bit full);
        chk((full ? f_done : done) == 1'b0, "R8 early", 1, 0);
        @(negedge clk);
        chk((full ? f_done : done) == 1'b1, "R8 pulse", 0, 1);
        chk((full ? f_valid : msg_valid) == 1'b0, "R8 no msg with done", 1, 0);
        @(negedge clk);
        chk((full ? f_done : done) == 1'b0, "R8 single", 1, 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(msg_valid == 1'b0, "R1 msg_valid", msg_valid, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(msg_val == '0, "R1 msg_val", msg_val, 0);
        pulse_start(1'b0);
        for (int i = 0; i < 4; i++) begin
            tick();
            expect_msg("R1 zero load", 1'b0, i, 0);
        end
        tick();
        expect_msg("R1 zero avg", 1'b1, 0, 0);
        expect_done_after(1'b0);
    endtask

    task automatic t_main_order();
        do_reset();
        add(0, 10); add(1, 50); add(2, 30); add(3, 50);
        add(4, 5);  add(5, 70); add(6, 20); add(7, 1);
        // R10 ticks while idle
        tick();
        chk(msg_valid == 1'b0, "R10 idle tick", msg_valid, 0);
        pulse_start(1'b0);
        // R3 change during exchange
        add(7, 1000);
        tick();
        expect_msg("R5 first", 1'b0, 5, 70);
        // R4 no message without tick
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(msg_valid == 1'b0, "R4 gap", msg_valid, 0);
        end
        // R9 start while busy
        pulse_start(1'b0);
        tick();
        expect_msg("R5 tie low id", 1'b0, 1, 50);
        tick();
        expect_msg("R5 tie next", 1'b0, 3, 50);
        tick();
        expect_msg("R5 fourth", 1'b0, 2, 30);
        tick();
        expect_msg("R6 R3 avg", 1'b1, 0, 9);
        expect_done_after(1'b0);
        tick();
        chk(msg_valid == 1'b0, "R10 after done", msg_valid, 0);
        // R3 update shows in next exchange
        pulse_start(1'b0);
        tick();
        expect_msg("R3 next exchange", 1'b0, 7, 1001);
        tick();
        expect_msg("R5 second", 1'b0, 5, 70);
        tick();
        expect_msg("R5 third", 1'b0, 1, 50);
        tick();
        expect_msg("R5 fourth b", 1'b0, 3, 50);
        tick();
        expect_msg("R6 floor avg", 1'b1, 0, 16);
        expect_done_after(1'b0);
    endtask

    task automatic t_sat_clamp();
        do_reset();
        add(0, 16'hFFFF); add(0, 16'hFFFF);
        add(6, 20); retire(6, 25);
        add(4, 7); add(7, 9); add(1, 3); add(2, 3); add(3, 3); add(5, 2);
        pulse_start(1'b0);
        tick();
        expect_msg("R2 saturate", 1'b0, 0, 65535);
        tick();
        expect_msg("R2 order", 1'b0, 7, 9);
        tick();
        expect_msg("R2 order b", 1'b0, 4, 7);
        tick();
        expect_msg("R2 order c", 1'b0, 1, 3);
        tick();
        expect_msg("R2 R6 clamp avg", 1'b1, 0, 2);
        expect_done_after(1'b0);
    endtask

    task automatic t_full_exchange();
        int exp_tid [8] = '{2, 6, 0, 1, 4, 5, 7, 3};
        int exp_val [8] = '{9, 9, 4, 4, 4, 2, 1, 0};
        do_reset();
        add(0, 4); add(1, 4); add(2, 9); add(4, 4);
        add(5, 2); add(6, 9); add(7, 1);
        pulse_start(1'b1);
        for (int i = 0; i < 8; i++) begin
            tick();
            expect_full("R7 exact", exp_tid[i], exp_val[i]);
        end
        expect_done_after(1'b1);
        tick();
        chk(f_valid == 1'b0, "R7 no avg", f_valid, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_main_order();
        t_sat_clamp();
        t_full_exchange();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule